// File: doc/BRIEF.md
# Pipeline Exception Entry Sequencer

This controller sits beside a five-stage in-order pipeline (prefetch, fetch, decode, address generation, execute) and decides where normal flow stops when an exception is accepted. It watches the execution set that is waiting in decode, together with that set's change-of-flow, disable-interrupt and delayed flags. It then chooses the decode slot that the exception takes over. In that slot it inserts a single push cycle, which writes the return PC and the status register to a stack-write port, pulses a fetch redirect to the vector address, and flushes the younger sets that were already fetched.

An accepted request is latched. Two execution sets must leave decode before the push may take a slot: the set in decode when the request arrives, and the one after it. The push may also only follow a set that does not change flow. A change-of-flow set, a delayed set (which keeps the delay-slot pair together) and, by default, a disable-interrupt set each push the entry back by one more set. Stalls and decode bubbles move nothing forward. The push slot is reported as it moves from decode through address generation and execute.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and after any later reset, stk_we, redir_valid, flush, busy, push_dec, push_agu and push_exe are all 0.
- R2: A request with req_mask=1 is ignored: busy stays 0 and no push occurs.
- R3: An unmasked request is accepted in a cycle with adv=1 and dec_valid=1, and the next decoded set carries no barrier flag. The push then occupies decode two cycles later. stk_pc equals the dec_pc of that cycle, which is the address of the third set after the request.
- R4: Each accepted request produces exactly one cycle with stk_we=1, and stk_sr equals status_in in that cycle.
- R5: In the push cycle, redir_valid=1, flush=1 and redir_addr equals the VECTOR parameter. In all other cycles redir_valid and flush are 0.
- R6: A set with dec_cof=1 cannot be the last set before the push. The push moves one set later, so the first target set still executes and the return address is the target set that follows it.
- R7: A set with dec_delayed=1 cannot be the last set before the push. The push lands after its delay slot.
- R8: With DI_BARRIER=1, a set with dec_di=1 defers entry in the same way as a change-of-flow set.
- R9: While adv=0 no set is counted, the push slot stays in decode with stk_we=0, and a request seen during the stall is latched.
- R10: push_agu is 1 in the cycle after an advancing push cycle. push_exe follows push_agu one advancing cycle later.
- R11: A request seen while busy=1 is merged into the pending one, and the pending entry is kept until its push cycle.
- R12: A cycle with dec_valid=0 and adv=1 is not counted as a passing set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Exception request |
| req_mask | input | 1 | Request masked when 1 |
| adv | input | 1 | Pipeline advances this cycle (0 = stall) |
| dec_valid | input | 1 | Decode holds a real execution set |
| dec_pc | input | PC_W | Address of the set in decode |
| dec_cof | input | 1 | Set in decode is a non-delayed change-of-flow |
| dec_di | input | 1 | Set in decode disables interrupts |
| dec_delayed | input | 1 | Set in decode is a delayed change-of-flow |
| status_in | input | SR_W | Current status register |
| stk_we | output | 1 | Stack write strobe (push cycle) |
| stk_pc | output | PC_W | Return address written to the stack |
| stk_sr | output | SR_W | Status written to the stack |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | PC_W | Redirect target (vector address) |
| flush | output | 1 | Discard younger fetched sets |
| busy | output | 1 | A request is pending or being entered |
| push_dec | output | 1 | Push slot occupies decode |
| push_agu | output | 1 | Push slot occupies address generation |
| push_exe | output | 1 | Push slot occupies execute |

## Verification
Two events can meet in one cycle. A new request can arrive while an earlier entry is still pending, and a stall can fall on the push cycle itself. The bench raises a second request while the first is held behind a decode bubble, and stalls the pipeline exactly in the push slot. It checks that only one stack write occurs, that the write comes on the first advancing cycle with the return address of the set then in decode, and that the occupancy flags wait through the stall.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_CLEAR = 2'd2,
      ST_PUSH  = 2'd3
   } entry_state_t;
endpackage

// File: rtl/exc_barrier_dec.sv
module exc_barrier_dec #(
   parameter bit DI_BARRIER = 1'b1
) (
   input  logic cof,
   input  logic di,
   input  logic dly,
   output logic barrier
);
   generate
      if (DI_BARRIER) begin : g_di_counts
         assign barrier = cof | di | dly;
      end else begin : g_di_free
         logic di_unused;
         assign di_unused = di;
         assign barrier = cof | dly;
      end
   endgenerate
endmodule

// File: rtl/exc_window_fsm.sv
module exc_window_fsm
   import exc_seq_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic         adv,
   input  logic         step,
   input  logic         barrier,
   output entry_state_t state
);
   entry_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (take) nxt = step ? ST_CLEAR : ST_FIRST;
         ST_FIRST: if (step) nxt = ST_CLEAR;
         ST_CLEAR: if (step && !barrier) nxt = ST_PUSH;
         ST_PUSH:  if (adv) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/exc_push_track.sv
module exc_push_track #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              in_slot,
   output logic [STAGES-1:0] occ
);
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic src;
         if (s == 0) begin : g_head
            assign src = in_slot;
         end else begin : g_tail
            assign src = occ[s-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   occ[s] <= 1'b0;
            else if (adv) occ[s] <= src;
         end
      end
   endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int            PC_W       = 16,
   parameter int            SR_W       = 16,
   parameter logic [PC_W-1:0] VECTOR   = 'h0100,
   parameter bit            DI_BARRIER = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            req_mask,
   input  logic            adv,
   input  logic            dec_valid,
   input  logic [PC_W-1:0] dec_pc,
   input  logic            dec_cof,
   input  logic            dec_di,
   input  logic            dec_delayed,
   input  logic [SR_W-1:0] status_in,
   output logic            stk_we,
   output logic [PC_W-1:0] stk_pc,
   output logic [SR_W-1:0] stk_sr,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_addr,
   output logic            flush,
   output logic            busy,
   output logic            push_dec,
   output logic            push_agu,
   output logic            push_exe
);
   localparam int LATER_STAGES = 2;

   generate
      if (PC_W < 2 || SR_W < 1) begin : g_bad_width
         $error("exc_entry_seq: PC_W must be >= 2 and SR_W >= 1");
      end
   endgenerate

   entry_state_t            state;
   logic                    barrier;
   logic                    step;
   logic                    take;
   logic                    commit;
   logic [LATER_STAGES-1:0] occ;

   assign take = req & ~req_mask;
   assign step = adv & dec_valid;

   exc_barrier_dec #(.DI_BARRIER(DI_BARRIER)) u_barrier (
      .cof     (dec_cof),
      .di      (dec_di),
      .dly     (dec_delayed),
      .barrier (barrier)
   );

   exc_window_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .adv     (adv),
      .step    (step),
      .barrier (barrier),
      .state   (state)
   );

   exc_push_track #(.STAGES(LATER_STAGES)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .in_slot (push_dec),
      .occ     (occ)
   );

   assign push_dec    = (state == ST_PUSH);
   assign busy        = (state != ST_IDLE);
   assign commit      = push_dec & adv;
   assign stk_we      = commit;
   assign redir_valid = commit;
   assign flush       = commit;
   assign redir_addr  = VECTOR;
   assign stk_pc      = push_dec ? dec_pc : '0;
   assign stk_sr      = push_dec ? status_in : '0;
   assign push_agu    = occ[0];
   assign push_exe    = occ[LATER_STAGES-1];
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int              PC_W   = 16,
   parameter logic [PC_W-1:0] VECTOR = 'h0100
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_mask,
   input logic            adv,
   input logic            stk_we,
   input logic            redir_valid,
   input logic [PC_W-1:0] redir_addr,
   input logic            flush,
   input logic            busy,
   input logic            push_dec,
   input logic            push_agu,
   input logic            push_exe
);
   // R4
   single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |=> !stk_we);

   // R5
   redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> (redir_addr == VECTOR && flush && stk_we));

   // R10
   agu_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |=> push_agu);

   // R10
   exe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_agu && adv) |=> push_exe);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_dec && !adv) |=> (push_dec && $stable(push_agu) && $stable(push_exe)));

   // R2
   masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_mask) |=> !busy);

   // R11
   pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !push_dec) |=> busy);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_mask    (req_mask),
   .adv         (adv),
   .stk_we      (stk_we),
   .redir_valid (redir_valid),
   .redir_addr  (redir_addr),
   .flush       (flush),
   .busy        (busy),
   .push_dec    (push_dec),
   .push_agu    (push_agu),
   .push_exe    (push_exe)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
   localparam int              PC_W   = 16;
   localparam int              SR_W   = 16;
   localparam logic [PC_W-1:0] VECTOR = 16'h0100;
   localparam logic [SR_W-1:0] STATUS = 16'h005A;
   localparam int              NROWS  = 35;

   typedef struct packed {
      logic req, mask, adv, val, cof, di, dly;
      logic [7:0] pc;
      logic we, bz, pd, pa, pe;
   } row_t;

   localparam row_t TBL [NROWS] = '{
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd10, 1'b0,1'b0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd11, 1'b0,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd12, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd13, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd20, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'd21, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd22, 1'b0,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd23, 1'b0,1'b0,1'b0,1'b0,1'b0},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd30, 1'b0,1'b0,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,8'd31, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd40, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd41, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd42, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,8'd51, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd52, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd60, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd61, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd70, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'd71, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd72, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd73, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd80, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd80, 1'b0,1'b1,1'b0,1'b1,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd80, 1'b0,1'b1,1'b0,1'b1,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd81, 1'b0,1'b1,1'b0,1'b0,1'b1},
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd82, 1'b0,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd82, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd83, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'd90, 1'b0,1'b0,1'b0,1'b0,1'b1},
      '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd90, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd91, 1'b0,1'b1,1'b0,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd92, 1'b1,1'b1,1'b1,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd93, 1'b0,1'b0,1'b0,1'b1,1'b0},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'd94, 1'b0,1'b0,1'b0,1'b0,1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req, req_mask, adv, dec_valid, dec_cof, dec_di, dec_delayed;
   logic [PC_W-1:0] dec_pc;
   logic [SR_W-1:0] status_in;
   logic            stk_we, redir_valid, flush, busy, push_dec, push_agu, push_exe;
   logic [PC_W-1:0] stk_pc, redir_addr;
   logic [SR_W-1:0] stk_sr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   exc_entry_seq #(.PC_W(PC_W), .SR_W(SR_W), .VECTOR(VECTOR), .DI_BARRIER(1'b1)) u_exc_entry_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_mask(req_mask), .adv(adv),
      .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_cof(dec_cof), .dec_di(dec_di),
      .dec_delayed(dec_delayed), .status_in(status_in), .stk_we(stk_we),
      .stk_pc(stk_pc), .stk_sr(stk_sr), .redir_valid(redir_valid),
      .redir_addr(redir_addr), .flush(flush), .busy(busy), .push_dec(push_dec),
      .push_agu(push_agu), .push_exe(push_exe)
   );

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int i);
      if (i <= 4)  return "R3";
      if (i <= 7)  return "R2";
      if (i <= 12) return "R6";
      if (i <= 17) return "R7";
      if (i <= 21) return "R8";
      if (i <= 28) return "R9";
      return "R12_R11";
   endfunction

   task automatic idle_inputs();
      req = 0; req_mask = 0; adv = 1; dec_valid = 1;
      dec_cof = 0; dec_di = 0; dec_delayed = 0; dec_pc = '0;
   endtask

   task automatic check_quiet(input string tag);
      check(tag, "stk_we",      {31'd0, stk_we},      32'd0);
      check(tag, "redir_valid", {31'd0, redir_valid}, 32'd0);
      check(tag, "flush",       {31'd0, flush},       32'd0);
      check(tag, "busy",        {31'd0, busy},        32'd0);
      check(tag, "push_dec",    {31'd0, push_dec},    32'd0);
      check(tag, "push_agu",    {31'd0, push_agu},    32'd0);
      check(tag, "push_exe",    {31'd0, push_exe},    32'd0);
   endtask

   initial begin
      status_in = STATUS;
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      #2 check_quiet("R1");
      rst_n = 1;

      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         req = TBL[i].req; req_mask = TBL[i].mask; adv = TBL[i].adv;
         dec_valid = TBL[i].val; dec_cof = TBL[i].cof; dec_di = TBL[i].di;
         dec_delayed = TBL[i].dly; dec_pc = {8'd0, TBL[i].pc};
         #2;
         check(tag_of(i), $sformatf("row %0d stk_we R4", i), {31'd0, stk_we}, {31'd0, TBL[i].we});
         check(tag_of(i), $sformatf("row %0d busy", i), {31'd0, busy}, {31'd0, TBL[i].bz});
         check(tag_of(i), $sformatf("row %0d redir/flush R5", i),
               {30'd0, redir_valid, flush}, {30'd0, TBL[i].we, TBL[i].we});
         check(tag_of(i), $sformatf("row %0d occupancy R10", i),
               {29'd0, push_dec, push_agu, push_exe},
               {29'd0, TBL[i].pd, TBL[i].pa, TBL[i].pe});
         if (TBL[i].we) begin
            check(tag_of(i), $sformatf("row %0d return pc", i), {16'd0, stk_pc}, {24'd0, TBL[i].pc});
            check("R4", $sformatf("row %0d stk_sr", i), {16'd0, stk_sr}, {16'd0, STATUS});
            check("R5", $sformatf("row %0d redir_addr", i), {16'd0, redir_addr}, {16'd0, VECTOR});
         end
      end

      // R1: reset taken in the middle of an entry clears everything
      @(negedge clk);
      idle_inputs(); req = 1; dec_pc = 16'd200;
      @(negedge clk);
      req = 0;
      #2 check("R1", "busy before mid reset", {31'd0, busy}, 32'd1);
      rst_n = 0;
      #1 check_quiet("R1");
      @(negedge clk);
      rst_n = 1;
      idle_inputs();
      @(negedge clk);
      #2 check_quiet("R1");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule